// File: doc/BRIEF.md
# Navigation Sentence Gate with Checksum Check

This block sits behind a serial byte receiver and watches the ASCII stream of a satellite navigation receiver. It finds the `$` that opens each sentence and matches the five header characters against three kept kinds: GGA, RMC and VTG. While it does this, it builds the XOR checksum of the same bytes. Any other header makes the block drop the sentence quietly until the next `$`.

For a kept sentence, the block marks every comma-delimited field and every data byte inside it with a field index and a byte position, so a downstream extractor can pick out the items it wants. After the `*`, two hex digits and a CR or LF, the block gives a one-cycle pass or fail verdict. A downstream extractor holds what it captured and commits it only on a pass.

The input is a valid/ready byte stream. `in_ready` is always high, so the block never applies back-pressure. A byte transfers on every rising clock edge where `in_valid` is high. All outputs are registered and respond on the edge that accepts the byte.

Top module: `nmea_sentence_gate`

## Requirements
- R1: `in_ready` is high from reset onward. A byte is consumed exactly on a rising edge with `in_valid` high, and its effect appears on the outputs one clock after it is presented. Cycles with `in_valid` low change nothing.
- R2: A `$` followed by the header `GPGGA`, `GPRMC` or `GPVTG` sets `sent_type` to 1, 2 or 3 respectively, from the cycle after the fifth header character until the verdict or an abort. Any other header (other talker, GSA, GSV, anything else) keeps `sent_type` at 0 and produces no strobes and no verdict until the next `$`.
- R3: In a kept sentence, the field index is 0 right after the header. Each comma raises `field_mark` for one cycle, with `field_num` incremented (the first comma gives 1) and `field_pos` at 0. Each other byte before `*` raises `field_valid` with the current `field_num` and a `field_pos` counting from 0 within the field. Empty fields give a mark and no data strobes.
- R4: The checksum is the XOR of all bytes strictly between `$` and `*`. The first digit after `*` is the high nibble. Digits may be `0-9`, `A-F` or `a-f`. If the value matches and the next byte is CR (0x0D) or LF (0x0A), `sent_ok` pulses for one cycle and `sent_type` returns to 0.
- R5: If the two digits are valid hex but the value differs, `sent_bad` pulses for one cycle on the CR/LF. `sent_ok` and `sent_bad` are never high together.
- R6: In a kept sentence, a non-hex byte in either checksum digit position, or any byte other than CR, LF or `$` right after the two digits, pulses `sent_bad` on that byte. The block then ignores bytes until the next `$`.
- R7: Counting `$` as position 1, any non-`$` byte at position `MAX_CHARS` (default 82) or later rejects the sentence. For a kept sentence this pulses `sent_bad` on that byte. A terminator at position 81 is still accepted.
- R8: A `$` at any point restarts parsing with a new sentence. The interrupted sentence gets no verdict.
- R9: After reset, all strobes and verdicts are low, `sent_type`, `field_num` and `field_pos` are 0, and `in_ready` is high.
- R10: Bytes outside a sentence, including bytes after a verdict or a rejection and before the next `$`, produce no output activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | 8 | Received ASCII byte |
| in_ready | output | 1 | Always high; no back-pressure |
| sent_type | output | 2 | 0 none, 1 GGA, 2 RMC, 3 VTG for the sentence in progress |
| field_mark | output | 1 | One-cycle pulse: a comma opened field `field_num` |
| field_valid | output | 1 | One-cycle pulse: data byte of field `field_num` at `field_pos` |
| field_num | output | $clog2(MAX_CHARS+1) | Field index of the current strobe |
| field_pos | output | $clog2(MAX_CHARS+1) | Byte position inside the field |
| sent_ok | output | 1 | One-cycle pulse: checksum matched at terminator |
| sent_bad | output | 1 | One-cycle pulse: kept sentence rejected |

## Verification
The hardest case to reach from the ports is the length limit. It needs a kept sentence whose terminator lands exactly on position 81, and a twin one byte longer, each with a correct checksum, so that only the length rule can decide the verdict. The bench builds these from a filler run of computed length and computes the checksum itself. It also covers a `$` arriving mid-field, lower-case digits, non-hex digits and trailing junk. A behavioural model driven by the same bytes predicts every output on every clock.

// File: rtl/nmea_gate_pkg.sv
package nmea_gate_pkg;
  localparam int HDR_LEN   = 5;
  localparam int NUM_KINDS = 3;
  localparam int KIND_W    = $clog2(NUM_KINDS + 1);

  // header templates, index k reported as type k+1
  localparam logic [8*HDR_LEN-1:0] KIND_HDR [NUM_KINDS] = '{"GPGGA", "GPRMC", "GPVTG"};

  localparam logic [7:0] CH_OPEN  = 8'h24;
  localparam logic [7:0] CH_STAR  = 8'h2A;
  localparam logic [7:0] CH_COMMA = 8'h2C;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_BODY, ST_CK_HI, ST_CK_LO, ST_TERM, ST_SKIP
  } gate_state_e;

  function automatic logic is_hex(input logic [7:0] c);
    return (c >= "0" && c <= "9") || (c >= "A" && c <= "F") || (c >= "a" && c <= "f");
  endfunction

  function automatic logic [3:0] hex_val(input logic [7:0] c);
    logic [7:0] v;
    if (c >= "a") v = c - 8'd87;
    else if (c >= "A") v = c - 8'd55;
    else v = c - 8'd48;
    return v[3:0];
  endfunction
endpackage

// File: rtl/nmea_hdr_match.sv
module nmea_hdr_match
  import nmea_gate_pkg::*;
(
  input  logic [2:0]           pos,
  input  logic [7:0]           ch,
  input  logic [NUM_KINDS-1:0] cand_in,
  output logic [NUM_KINDS-1:0] cand_out
);
  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    logic [8*HDR_LEN-1:0] shifted;
    assign shifted     = KIND_HDR[k] << (8 * pos);
    assign cand_out[k] = cand_in[k] && (shifted[8*HDR_LEN-1 -: 8] == ch);
  end
endmodule

// File: rtl/nmea_cksum.sv
module nmea_cksum
  import nmea_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       accum,
  input  logic       latch_hi,
  input  logic [7:0] ch,
  output logic [7:0] sum,
  output logic [3:0] hi_nib
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum    <= '0;
      hi_nib <= '0;
    end else begin
      if (clear)      sum <= '0;
      else if (accum) sum <= sum ^ ch;
      if (latch_hi) hi_nib <= hex_val(ch);
    end
  end
endmodule

// File: rtl/nmea_field_track.sv
module nmea_field_track #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             comma_ev,
  input  logic             data_ev,
  output logic             mark,
  output logic             valid,
  output logic [CNT_W-1:0] num_o,
  output logic [CNT_W-1:0] pos_o
);
  logic [CNT_W-1:0] num_q, cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q <= '0; cnt_q <= '0; mark <= 1'b0; valid <= 1'b0;
      num_o <= '0; pos_o <= '0;
    end else begin
      mark  <= 1'b0;
      valid <= 1'b0;
      if (restart) begin
        num_q <= '0;
        cnt_q <= '0;
      end else if (comma_ev) begin
        num_q <= num_q + 1'b1;
        cnt_q <= '0;
        mark  <= 1'b1;
        num_o <= num_q + 1'b1;
        pos_o <= '0;
      end else if (data_ev) begin
        cnt_q <= cnt_q + 1'b1;
        valid <= 1'b1;
        num_o <= num_q;
        pos_o <= cnt_q;
      end
    end
  end
endmodule

// File: rtl/nmea_sentence_gate.sv
module nmea_sentence_gate
  import nmea_gate_pkg::*;
#(
  parameter int MAX_CHARS = 82
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [7:0]                     in_data,
  output logic                           in_ready,
  output logic [1:0]                     sent_type,
  output logic                           field_mark,
  output logic                           field_valid,
  output logic [$clog2(MAX_CHARS+1)-1:0] field_num,
  output logic [$clog2(MAX_CHARS+1)-1:0] field_pos,
  output logic                           sent_ok,
  output logic                           sent_bad
);
  localparam int LEN_W = $clog2(MAX_CHARS + 1);

  gate_state_e st, st_n;
  logic [2:0]           hpos, hpos_n;
  logic [NUM_KINDS-1:0] cand, cand_n, cand_hit;
  logic [1:0]           kind, kind_n, enc;
  logic [LEN_W-1:0]     len, len_n;
  logic                 match, match_n, ok_n, bad_n;
  logic                 ck_clear, ck_acc, ck_hi;
  logic                 f_restart, f_comma, f_data;
  logic [7:0]           ck_sum;
  logic [3:0]           ck_hi_nib;
  logic                 active, kept;

  assign in_ready = 1'b1;

  nmea_hdr_match u_hdr (.pos(hpos), .ch(in_data), .cand_in(cand), .cand_out(cand_hit));

  nmea_cksum u_ck (
    .clk(clk), .rst_n(rst_n), .clear(ck_clear), .accum(ck_acc), .latch_hi(ck_hi),
    .ch(in_data), .sum(ck_sum), .hi_nib(ck_hi_nib)
  );

  nmea_field_track #(.CNT_W(LEN_W)) u_fld (
    .clk(clk), .rst_n(rst_n), .restart(f_restart), .comma_ev(f_comma), .data_ev(f_data),
    .mark(field_mark), .valid(field_valid), .num_o(field_num), .pos_o(field_pos)
  );

  always_comb begin
    enc = '0;
    for (int k = 0; k < NUM_KINDS; k++)
      if (cand_hit[k]) enc = 2'(k + 1);
  end

  assign active = st inside {ST_HDR, ST_BODY, ST_CK_HI, ST_CK_LO, ST_TERM};
  assign kept   = st inside {ST_BODY, ST_CK_HI, ST_CK_LO, ST_TERM};

  always_comb begin
    st_n = st; hpos_n = hpos; cand_n = cand; kind_n = kind; len_n = len; match_n = match;
    ok_n = 1'b0; bad_n = 1'b0;
    ck_clear = 1'b0; ck_acc = 1'b0; ck_hi = 1'b0;
    f_restart = 1'b0; f_comma = 1'b0; f_data = 1'b0;
    if (in_valid) begin
      if (in_data == CH_OPEN) begin
        st_n = ST_HDR; hpos_n = '0; cand_n = '1; len_n = LEN_W'(1); ck_clear = 1'b1;
      end else if (active && len >= LEN_W'(MAX_CHARS - 1)) begin
        st_n  = ST_SKIP;
        bad_n = kept;
      end else begin
        if (active) len_n = len + 1'b1;
        case (st)
          ST_HDR: begin
            ck_acc = 1'b1;
            cand_n = cand_hit;
            if (cand_hit == '0) st_n = ST_SKIP;
            else if (hpos == 3'(HDR_LEN - 1)) begin
              st_n = ST_BODY; kind_n = enc; f_restart = 1'b1;
            end else hpos_n = hpos + 1'b1;
          end
          ST_BODY: begin
            if (in_data == CH_STAR) st_n = ST_CK_HI;
            else begin
              ck_acc = 1'b1;
              if (in_data == CH_COMMA) f_comma = 1'b1;
              else f_data = 1'b1;
            end
          end
          ST_CK_HI: begin
            if (is_hex(in_data)) begin ck_hi = 1'b1; st_n = ST_CK_LO; end
            else begin bad_n = 1'b1; st_n = ST_SKIP; end
          end
          ST_CK_LO: begin
            if (is_hex(in_data)) begin
              match_n = ({ck_hi_nib, hex_val(in_data)} == ck_sum);
              st_n    = ST_TERM;
            end else begin bad_n = 1'b1; st_n = ST_SKIP; end
          end
          ST_TERM: begin
            if (in_data == CH_CR || in_data == CH_LF) begin
              ok_n = match; bad_n = !match; st_n = ST_IDLE;
            end else begin bad_n = 1'b1; st_n = ST_SKIP; end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; hpos <= '0; cand <= '0; kind <= '0; len <= '0; match <= 1'b0;
      sent_ok <= 1'b0; sent_bad <= 1'b0; sent_type <= '0;
    end else begin
      st <= st_n; hpos <= hpos_n; cand <= cand_n; kind <= kind_n; len <= len_n;
      match <= match_n; sent_ok <= ok_n; sent_bad <= bad_n;
      sent_type <= (st_n inside {ST_BODY, ST_CK_HI, ST_CK_LO, ST_TERM}) ? kind_n : 2'd0;
    end
  end
endmodule

// File: rtl/nmea_gate_chk.sv
module nmea_gate_chk #(
  parameter int POS_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       sent_type,
  input logic             field_mark,
  input logic             field_valid,
  input logic [POS_W-1:0] field_pos,
  input logic             sent_ok,
  input logic             sent_bad
);
  // R5
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sent_ok && sent_bad));
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(field_mark && field_valid));
  // R3
  mark_pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_mark |-> field_pos == '0);
  // R2
  strobe_needs_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_mark || field_valid) |-> sent_type != 2'd0);
  // R4
  verdict_clears_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_ok || sent_bad) |-> sent_type == 2'd0);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(field_mark || field_valid || sent_ok || sent_bad));
  // R1
  type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(sent_type));
endmodule

bind nmea_sentence_gate nmea_gate_chk #(.POS_W($clog2(MAX_CHARS+1))) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sent_type(sent_type),
  .field_mark(field_mark), .field_valid(field_valid), .field_pos(field_pos),
  .sent_ok(sent_ok), .sent_bad(sent_bad)
);

// File: tb/nmea_sentence_gate_bench.sv
module nmea_sentence_gate_bench;
  localparam int CLK_NS = 10;
  localparam int MAXC   = 82;
  localparam int W      = $clog2(MAXC + 1);

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, field_mark, field_valid, sent_ok, sent_bad;
  logic [1:0] sent_type;
  logic [W-1:0] field_num, field_pos;

  always #(CLK_NS/2) clk = ~clk;

  nmea_sentence_gate #(.MAX_CHARS(MAXC)) u_nmea_sentence_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .sent_type(sent_type), .field_mark(field_mark), .field_valid(field_valid),
    .field_num(field_num), .field_pos(field_pos), .sent_ok(sent_ok), .sent_bad(sent_bad)
  );

  int n_cmp = 0, n_bad = 0;
  int t_ok = 0, t_bad = 0, t_mark = 0, t_data = 0, t_type = 0;
  bit done = 0;

  // behavioural reference state
  string kinds[3] = '{"GPGGA", "GPRMC", "GPVTG"};
  int m_mode = 0; // 0 outside, 1 header, 2 body, 3 digit1, 4 digit2, 5 terminator, 6 discard
  string m_hdr;
  int m_sum, m_len, m_fnum, m_fpos, m_hi, m_match;
  int e_type = 0, e_num = 0, e_pos = 0;
  bit e_ok = 0, e_bad = 0, e_mark = 0, e_data = 0;

  function automatic int hexv(input logic [7:0] c);
    if (c >= "0" && c <= "9") return c - 48;
    if (c >= "A" && c <= "F") return c - 55;
    if (c >= "a" && c <= "f") return c - 87;
    return -1;
  endfunction

  task automatic reject(input bit flag);
    e_bad = flag; m_mode = 6; e_type = 0;
  endtask

  task automatic model(input logic v, input logic [7:0] b);
    int hv;
    bit any;
    e_ok = 0; e_bad = 0; e_mark = 0; e_data = 0;
    if (!v) return;
    if (b == 8'h24) begin
      m_mode = 1; m_hdr = ""; m_sum = 0; m_len = 1; e_type = 0; return;
    end
    if (m_mode >= 1 && m_mode <= 5) begin
      if (m_len >= MAXC - 1) begin reject(m_mode >= 2); return; end
      m_len++;
    end
    case (m_mode)
      1: begin
        m_sum ^= b;
        m_hdr = $sformatf("%s%c", m_hdr, b);
        any = 0;
        foreach (kinds[t]) if (kinds[t].substr(0, m_hdr.len() - 1) == m_hdr) any = 1;
        if (!any) m_mode = 6;
        else if (m_hdr.len() == 5) begin
          foreach (kinds[t]) if (kinds[t] == m_hdr) e_type = t + 1;
          m_mode = 2; m_fnum = 0; m_fpos = 0;
        end
      end
      2: begin
        if (b == 8'h2A) m_mode = 3;
        else begin
          m_sum ^= b;
          if (b == 8'h2C) begin m_fnum++; m_fpos = 0; e_mark = 1; e_num = m_fnum; e_pos = 0; end
          else begin e_data = 1; e_num = m_fnum; e_pos = m_fpos; m_fpos++; end
        end
      end
      3: begin
        hv = hexv(b);
        if (hv < 0) reject(1); else begin m_hi = hv; m_mode = 4; end
      end
      4: begin
        hv = hexv(b);
        if (hv < 0) reject(1); else begin m_match = (m_hi * 16 + hv) == m_sum; m_mode = 5; end
      end
      5: begin
        if (b == 8'h0D || b == 8'h0A) begin
          e_ok = m_match; e_bad = !m_match; m_mode = 0; e_type = 0;
        end else reject(1);
      end
      default: ;
    endcase
  endtask

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_cmp++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_now();
    bit bad;
    bad = 0;
    if (sent_type != e_type[1:0]) begin bad = 1; $display("FAIL R2 sent_type actual=%0d expected=%0d", sent_type, e_type); end
    if (field_mark != e_mark || field_valid != e_data) begin
      bad = 1; $display("FAIL R3 mark/valid actual=%0d/%0d expected=%0d/%0d", field_mark, field_valid, e_mark, e_data);
    end else if ((e_mark || e_data) && (field_num != W'(e_num) || field_pos != W'(e_pos))) begin
      bad = 1; $display("FAIL R3 num/pos actual=%0d/%0d expected=%0d/%0d", field_num, field_pos, e_num, e_pos);
    end
    if (sent_ok != e_ok) begin bad = 1; $display("FAIL R4 sent_ok actual=%0d expected=%0d", sent_ok, e_ok); end
    if (sent_bad != e_bad) begin bad = 1; $display("FAIL R5 sent_bad actual=%0d expected=%0d", sent_bad, e_bad); end
    if (in_ready !== 1'b1) begin bad = 1; $display("FAIL R1 in_ready actual=%0d expected=1", in_ready); end
    n_cmp++;
    if (bad) n_bad++;
    t_ok += sent_ok; t_bad += sent_bad; t_mark += field_mark; t_data += field_valid;
    if (sent_type != 0) t_type = sent_type;
  endtask

  task automatic step(input logic v, input logic [7:0] b);
    @(negedge clk);
    compare_now();
    in_valid = v; in_data = b;
    model(v, b);
  endtask

  task automatic send(input string s, input int gap);
    for (int i = 0; i < s.len(); i++) begin
      step(1'b1, s[i]);
      for (int g = 0; g < gap; g++) step(1'b0, 8'h00);
    end
    step(1'b0, 8'h00);
    step(1'b0, 8'h00);
  endtask

  function automatic string mk(input string body, input bit lower, input int flip);
    int x = 0;
    for (int i = 0; i < body.len(); i++) x ^= body[i];
    x ^= flip;
    if (lower) return $sformatf("$%s*%02x\r\n", body, x);
    return $sformatf("$%s*%02X\r\n", body, x);
  endfunction

  task automatic clr();
    t_ok = 0; t_bad = 0; t_mark = 0; t_data = 0; t_type = 0;
  endtask

  function automatic string filler(input int n);
    string s = "GPGGA,";
    for (int i = 0; i < n; i++) s = {s, "9"};
    return s;
  endfunction

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(sent_type == 0 && !sent_ok && !sent_bad && !field_mark && !field_valid, "R9", sent_type, 0);
    check(field_num == 0 && field_pos == 0 && in_ready, "R9", field_num, 0);
    rst_n = 1'b1;
    step(1'b0, 8'h00);

    clr(); send(mk("GPGGA,101530.00,4807.038,N,01131.000,E,1,08,,", 0, 0), 0);
    check(t_ok == 1 && t_bad == 0, "R4", t_ok, 1);
    check(t_type == 1, "R2", t_type, 1);
    check(t_mark == 9, "R3", t_mark, 9);

    clr(); send(mk("GPRMC,082211,A,5133.82,N,00042.24,W,,,230394,,", 1, 0), 0);
    check(t_ok == 1 && t_bad == 0, "R4", t_ok, 1);
    check(t_type == 2, "R2", t_type, 2);

    clr(); send(mk("GPVTG,a,,bc", 0, 8'h21), 0);
    check(t_bad == 1 && t_ok == 0, "R5", t_bad, 1);
    check(t_mark == 3 && t_data == 3 && t_type == 3, "R3", t_data, 3);

    clr(); send(mk("GPGSV,3,1,11,03,03,111,00", 0, 0), 0);
    check(t_ok + t_bad + t_mark + t_data + t_type == 0, "R2", t_mark + t_data, 0);
    clr(); send(mk("GNGGA,1,2", 0, 0), 0);
    check(t_ok + t_bad + t_mark + t_data + t_type == 0, "R2", t_data, 0);

    clr(); send("$GPGGA,12*4G\r\n,abc*00\r\n", 0);
    check(t_bad == 1 && t_ok == 0, "R6", t_bad, 1);
    clr(); send("$GPRMC,5*G1\r\n", 0);
    check(t_bad == 1, "R6", t_bad, 1);
    clr(); send({mk("GPVTG,7", 0, 0).substr(0, 10), "X\r\n"}, 0);
    check(t_bad == 1 && t_ok == 0, "R6", t_bad, 1);

    clr(); send({"$GPGGA,12,3", mk("GPRMC,1,2", 0, 0)}, 0);
    check(t_ok == 1 && t_bad == 0, "R8", t_ok, 1);

    clr(); send(mk(filler(70), 0, 0), 0);
    check(t_ok == 1 && t_bad == 0, "R7", t_ok, 1);
    clr(); send(mk(filler(71), 0, 0), 0);
    check(t_bad == 1 && t_ok == 0, "R7", t_bad, 1);
    clr(); send(mk(filler(90), 0, 0), 0);
    check(t_bad == 1 && t_ok == 0, "R7", t_bad, 1);

    clr(); send(mk("GPGGA,4,5,,6", 1, 0), 2);
    check(t_ok == 1 && t_data == 3, "R1", t_ok, 1);

    clr(); send("noise,*12\r\nGPGGA,1*00\r\n", 0);
    check(t_ok + t_bad + t_mark + t_data == 0, "R10", t_mark + t_data, 0);

    repeat (4) step(1'b0, 8'h00);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule